// File: doc/BRIEF.md
# Pulse-Framed Stereo PCM Serial Port

This block moves stereo PCM samples over a four-wire serial link (bit clock, frame sync, data in, data out) using pulse framing. The frame sync does not say which channel is on the wire. Its leading edge only marks where a frame begins. Inside each frame the left word goes out MSB first, and the right word follows it at once with no gap. Every remaining bit slot up to the end of the frame carries zero.

The transmit side takes a left/right pair over a valid/ready handshake into a one-deep holding stage. It loads that pair at each frame start. When no pair is waiting, it sends a silent frame and sets a sticky underrun flag. The receive side collects both words and presents them together with a one-cycle valid strobe once the last right-channel bit is in.

Configuration inputs select:
- the word length, from 16 to 32 bits;
- the frame length;
- the data offset: the MSB either one bit clock after the sync edge, or in the same bit clock as the sync edge;
- which bit-clock edge samples;
- master or slave mode.

In master mode the port divides the system clock to make the bit clock and drives a one-bit-clock sync pulse. In slave mode the bit clock and sync are inputs, oversampled by the system clock.

Top module: `dsp_serial_port`

## Requirements
- R1: In slave mode a frame starts at the first sampling edge where frame sync is seen high after being low. That slot is slot 0. The port keeps the same slot counting for any sync pulse width from 1 to frame length minus 1 bit clocks.
- R2: In master mode fsync_o is high for exactly one bit-clock period per frame, and it is launched together with slot 0. In slave mode fsync_o stays 0.
- R3: With cfg_fmt_b = 0 the left MSB occupies slot 1. With cfg_fmt_b = 1 it occupies slot 0. Format A requires a frame length of at least 2*word length + 1, and format B at least 2*word length.
- R4: The transmitted frame holds the left word and then the right word, MSB first and back to back. All later slots carry 0. Sample words are LSB-justified, and bits at or above the word length of tx_l/tx_r are not sent.
- R5: With cfg_bclk_fall = 0, data and sync are sampled on the rising bit-clock edge and launched on the falling edge. With cfg_bclk_fall = 1 the two edges are swapped.
- R6: After the last right-channel bit has been sampled, rx_l and rx_r hold the received words, LSB-justified with zeros above the word length, and rx_valid is high for one system clock.
- R7: tx_ready is high while the holding stage is empty. An accepted pair is loaded at the next frame start, which frees the holding stage again.
- R8: If the holding stage is empty at a frame start, that frame transmits all zeros and underrun goes to 1. It stays at 1 until reset.
- R9: In master mode bclk_o toggles every cfg_div system clocks (cfg_div of at least 4). It rests at the level opposite the launch edge after reset, so the first edge is a launch. In slave mode bclk_o holds that level.
- R10: Synchronous reset (rst_n = 0) gives tx_ready = 1, rx_valid = 0, underrun = 0, fsync_o = 0 and sdout = 0.
- R11: sdout changes only in the system clock that follows a launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1: port generates bit clock and sync |
| cfg_fmt_b | input | 1 | 0: MSB one slot after sync, 1: MSB at sync slot |
| cfg_bclk_fall | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfg_word_len | input | 6 | Word length in bits (16..32) |
| cfg_frame_len | input | 8 | Frame length in bit clocks |
| cfg_div | input | 8 | Master bit-clock half period in system clocks |
| bclk_i | input | 1 | Bit clock from the link (slave) |
| fsync_i | input | 1 | Frame sync from the link (slave) |
| sdin | input | 1 | Serial receive data |
| bclk_o | output | 1 | Generated bit clock (master) |
| fsync_o | output | 1 | Generated frame sync (master) |
| sdout | output | 1 | Serial transmit data |
| tx_l | input | 32 | Left transmit sample |
| tx_r | input | 32 | Right transmit sample |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Holding stage empty |
| rx_l | output | 32 | Received left sample |
| rx_r | output | 32 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe for a received pair |
| underrun | output | 1 | Sticky: a frame started with no pair held |

## Verification
Some properties are checked on every cycle: sdout moves only after launch edges, rx_valid never lasts two cycles, a master sync pulse ends at the next launch, fsync_o stays low in slave mode, underrun never clears, and an accepted pair always drops tx_ready. The slot placement of each bit under both offsets and both edge selections can only be shown by the bench's frames. So can zero fill, masking of the upper sample bits, tolerance of wide sync pulses, the silent underrun frame, and the master clock and sync timing. The bench compares these against sequences it computes itself.

// File: rtl/dsp_port_pkg.sv
package dsp_port_pkg;

   // Bit-clock event strobes, one system clock wide.
   typedef struct packed {
      logic smp;   // sampling edge of the active bit clock
      logic lch;   // launching edge of the active bit clock
   } bclk_stb_t;

endpackage

// File: rtl/dsp_port_clkgen.sv
module dsp_port_clkgen
   import dsp_port_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_master,
   input  logic             cfg_bclk_fall,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             bclk_i,
   input  logic             fsync_i,
   input  logic             sdin,
   output logic             bclk_o,
   output bclk_stb_t        stb,
   output logic             fs_s,
   output logic             sd_s
);
   localparam logic [DIV_W-1:0] ONE_D = 1;

   logic [SYNC_STAGES-1:0] bc_sy, fs_sy, sd_sy;
   logic                   bc_prev;
   logic [DIV_W-1:0]       dcnt;
   logic                   tick, rise, fall;

   // Input synchronisers: not reset, they follow the pins.
   always_ff @(posedge clk) begin
      bc_sy[0] <= bclk_i;
      fs_sy[0] <= fsync_i;
      sd_sy[0] <= sdin;
   end

   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         bc_sy[i] <= bc_sy[i-1];
         fs_sy[i] <= fs_sy[i-1];
         sd_sy[i] <= sd_sy[i-1];
      end
   end

   always_ff @(posedge clk) bc_prev <= bc_sy[SYNC_STAGES-1];

   assign fs_s = fs_sy[SYNC_STAGES-1];
   assign sd_s = sd_sy[SYNC_STAGES-1];

   // Master divider: half period of cfg_div system clocks.
   assign tick = cfg_master && (dcnt == cfg_div - ONE_D);

   always_ff @(posedge clk) begin
      if (!rst_n || !cfg_master) begin
         dcnt   <= '0;
         bclk_o <= !cfg_bclk_fall;
      end else if (tick) begin
         dcnt   <= '0;
         bclk_o <= !bclk_o;
      end else begin
         dcnt   <= dcnt + ONE_D;
      end
   end

   always_comb begin
      if (cfg_master) begin
         rise = tick && !bclk_o;
         fall = tick && bclk_o;
      end else begin
         rise = bc_sy[SYNC_STAGES-1] && !bc_prev;
         fall = !bc_sy[SYNC_STAGES-1] && bc_prev;
      end
      stb.smp = cfg_bclk_fall ? fall : rise;
      stb.lch = cfg_bclk_fall ? rise : fall;
   end

endmodule

// File: rtl/dsp_port_framer.sv
module dsp_port_framer #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_master,
   input  logic [FRAME_W-1:0] cfg_frame_len,
   input  logic               smp,
   input  logic               fs_s,
   output logic [FRAME_W-1:0] slot_now,
   output logic [FRAME_W-1:0] slot_next
);
   localparam logic [FRAME_W-1:0] ONE_F = 1;

   logic [FRAME_W-1:0] cnt;
   logic               fs_prev, fs_rise;

   // Only the leading edge of an external sync restarts the count.
   assign fs_rise   = !cfg_master && fs_s && !fs_prev;
   assign slot_next = (cnt >= cfg_frame_len - ONE_F) ? '0 : cnt + ONE_F;
   assign slot_now  = fs_rise ? '0 : slot_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= cfg_frame_len - ONE_F;
         fs_prev <= 1'b0;
      end else if (smp) begin
         cnt     <= slot_now;
         fs_prev <= fs_s;
      end
   end

endmodule

// File: rtl/dsp_port_tx.sv
module dsp_port_tx #(
   parameter int MAX_WORD = 32,
   parameter int FRAME_W  = 8,
   parameter int WL_W     = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_master,
   input  logic                cfg_fmt_b,
   input  logic [WL_W-1:0]     cfg_word_len,
   input  logic                lch,
   input  logic [FRAME_W-1:0]  slot_next,
   input  logic [MAX_WORD-1:0] tx_l,
   input  logic [MAX_WORD-1:0] tx_r,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic                sdout,
   output logic                fsync_o,
   output logic                underrun
);
   localparam int            IW  = $clog2(MAX_WORD);
   localparam logic [FRAME_W:0] ONE = 1;

   logic                hold_full;
   logic [MAX_WORD-1:0] hold_l, hold_r, frm_l, frm_r, src_l, src_r;
   logic                start, accept, bit_v;
   logic [FRAME_W:0]    p, wlx, wl2, offx, slotx;

   assign tx_ready = !hold_full;
   assign accept   = tx_valid && !hold_full;
   assign start    = lch && (slot_next == '0);

   assign src_l = start ? (hold_full ? hold_l : '0) : frm_l;
   assign src_r = start ? (hold_full ? hold_r : '0) : frm_r;

   always_comb begin
      wlx   = {{(FRAME_W+1-WL_W){1'b0}}, cfg_word_len};
      wl2   = wlx << 1;
      offx  = {{FRAME_W{1'b0}}, !cfg_fmt_b};
      slotx = {1'b0, slot_next};
      p     = slotx - offx;
      bit_v = 1'b0;
      if (slotx >= offx) begin
         if (p < wlx)      bit_v = src_l[IW'(wlx - p - ONE)];
         else if (p < wl2) bit_v = src_r[IW'(wl2 - p - ONE)];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_l    <= '0;
         hold_r    <= '0;
         frm_l     <= '0;
         frm_r     <= '0;
         sdout     <= 1'b0;
         fsync_o   <= 1'b0;
         underrun  <= 1'b0;
      end else begin
         if (accept) begin
            hold_full <= 1'b1;
            hold_l    <= tx_l;
            hold_r    <= tx_r;
         end else if (start) begin
            hold_full <= 1'b0;
         end
         if (start) begin
            frm_l <= src_l;
            frm_r <= src_r;
            if (!hold_full) underrun <= 1'b1;
         end
         if (lch) begin
            sdout   <= bit_v;
            fsync_o <= cfg_master && (slot_next == '0);
         end
      end
   end

endmodule

// File: rtl/dsp_port_rx.sv
module dsp_port_rx #(
   parameter int MAX_WORD = 32,
   parameter int FRAME_W  = 8,
   parameter int WL_W     = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_fmt_b,
   input  logic [WL_W-1:0]     cfg_word_len,
   input  logic                smp,
   input  logic [FRAME_W-1:0]  slot_now,
   input  logic                sd_s,
   output logic [MAX_WORD-1:0] rx_l,
   output logic [MAX_WORD-1:0] rx_r,
   output logic                rx_valid
);
   localparam logic [FRAME_W:0] ONE = 1;

   logic [MAX_WORD-1:0] sh_l, sh_r;
   logic [FRAME_W:0]    p, wlx, wl2, offx, slotx;

   always_comb begin
      wlx   = {{(FRAME_W+1-WL_W){1'b0}}, cfg_word_len};
      wl2   = wlx << 1;
      offx  = {{FRAME_W{1'b0}}, !cfg_fmt_b};
      slotx = {1'b0, slot_now};
      p     = slotx - offx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_l     <= '0;
         sh_r     <= '0;
         rx_l     <= '0;
         rx_r     <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (smp && slotx >= offx) begin
            if (p < wlx) begin
               sh_l <= (p == '0) ? {{(MAX_WORD-1){1'b0}}, sd_s}
                                 : {sh_l[MAX_WORD-2:0], sd_s};
            end else if (p < wl2) begin
               sh_r <= (p == wlx) ? {{(MAX_WORD-1){1'b0}}, sd_s}
                                  : {sh_r[MAX_WORD-2:0], sd_s};
               if (p == wl2 - ONE) begin
                  rx_l     <= sh_l;
                  rx_r     <= {sh_r[MAX_WORD-2:0], sd_s};
                  rx_valid <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dsp_serial_port.sv
module dsp_serial_port
   import dsp_port_pkg::*;
#(
   parameter int MAX_WORD    = 32,
   parameter int FRAME_W     = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int WL_W       = $clog2(MAX_WORD + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_master,
   input  logic                cfg_fmt_b,
   input  logic                cfg_bclk_fall,
   input  logic [WL_W-1:0]     cfg_word_len,
   input  logic [FRAME_W-1:0]  cfg_frame_len,
   input  logic [DIV_W-1:0]    cfg_div,
   input  logic                bclk_i,
   input  logic                fsync_i,
   input  logic                sdin,
   output logic                bclk_o,
   output logic                fsync_o,
   output logic                sdout,
   input  logic [MAX_WORD-1:0] tx_l,
   input  logic [MAX_WORD-1:0] tx_r,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic [MAX_WORD-1:0] rx_l,
   output logic [MAX_WORD-1:0] rx_r,
   output logic                rx_valid,
   output logic                underrun
);
   if (MAX_WORD < 16) begin : g_bad_word
      $error("MAX_WORD must be at least 16");
   end
   if ((1 << FRAME_W) <= 2 * MAX_WORD + 1) begin : g_bad_frame
      $error("FRAME_W too narrow for two words plus offset");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   bclk_stb_t          stb;
   logic               smp_w, lch_w, fs_s, sd_s;
   logic [FRAME_W-1:0] slot_now, slot_next;

   assign smp_w = stb.smp;
   assign lch_w = stb.lch;

   dsp_port_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
      .cfg_bclk_fall(cfg_bclk_fall), .cfg_div(cfg_div),
      .bclk_i(bclk_i), .fsync_i(fsync_i), .sdin(sdin),
      .bclk_o(bclk_o), .stb(stb), .fs_s(fs_s), .sd_s(sd_s)
   );

   dsp_port_framer #(.FRAME_W(FRAME_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
      .cfg_frame_len(cfg_frame_len), .smp(smp_w), .fs_s(fs_s),
      .slot_now(slot_now), .slot_next(slot_next)
   );

   dsp_port_tx #(.MAX_WORD(MAX_WORD), .FRAME_W(FRAME_W), .WL_W(WL_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
      .cfg_fmt_b(cfg_fmt_b), .cfg_word_len(cfg_word_len),
      .lch(lch_w), .slot_next(slot_next),
      .tx_l(tx_l), .tx_r(tx_r), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .sdout(sdout), .fsync_o(fsync_o), .underrun(underrun)
   );

   dsp_port_rx #(.MAX_WORD(MAX_WORD), .FRAME_W(FRAME_W), .WL_W(WL_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cfg_fmt_b(cfg_fmt_b),
      .cfg_word_len(cfg_word_len), .smp(smp_w), .slot_now(slot_now),
      .sd_s(sd_s), .rx_l(rx_l), .rx_r(rx_r), .rx_valid(rx_valid)
   );

endmodule

// File: rtl/dsp_serial_port_chk.sv
module dsp_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_master,
   input logic lch,
   input logic bclk_o,
   input logic fsync_o,
   input logic sdout,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic underrun
);
   AST_SDOUT_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      !lch |=> $stable(sdout));                                      // R11
   AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                       // R6
   AST_MASTER_FS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master && lch && fsync_o |=> !fsync_o);                    // R2
   AST_SLAVE_FS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> !fsync_o);                                     // R2
   AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);                                        // R8
   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_ready);                           // R7
   AST_SLAVE_BCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master && $past(!cfg_master) |-> $stable(bclk_o));        // R9
endmodule

bind dsp_serial_port dsp_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .lch(lch_w),
   .bclk_o(bclk_o), .fsync_o(fsync_o), .sdout(sdout),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
   .underrun(underrun)
);

// File: tb/dsp_serial_port_test.sv
module dsp_serial_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int NVEC       = 7;

   // {has_tx, fmt_b, bclk_fall, word_len[6], frame_len[8], fs_width[8], rxl[32], rxr[32]}
   typedef logic [88:0] vec_t;
   localparam vec_t VEC [NVEC] = '{
      {1'b1, 1'b0, 1'b0, 6'd16, 8'd33, 8'd1,  32'h0000_A5C3, 32'h0000_3C5A},
      {1'b1, 1'b1, 1'b0, 6'd16, 8'd32, 8'd1,  32'hFFFF_8001, 32'h1234_7FFE},
      {1'b1, 1'b0, 1'b1, 6'd24, 8'd60, 8'd5,  32'h00C0_FFEE, 32'h0012_3456},
      {1'b1, 1'b1, 1'b1, 6'd32, 8'd64, 8'd63, 32'hDEAD_BEEF, 32'h8000_0001},
      {1'b1, 1'b0, 1'b0, 6'd20, 8'd48, 8'd47, 32'h000F_0F0F, 32'h000A_AAAA},
      {1'b0, 1'b1, 1'b0, 6'd16, 8'd40, 8'd2,  32'h0000_1357, 32'h0000_9BDF},
      {1'b1, 1'b1, 1'b1, 6'd18, 8'd37, 8'd10, 32'h0003_0001, 32'h0002_FFFF}
   };

   logic        clk = 0, rst_n = 0;
   logic        cfg_master = 0, cfg_fmt_b = 0, cfg_bclk_fall = 0;
   logic [5:0]  cfg_word_len = 6'd16;
   logic [7:0]  cfg_frame_len = 8'd40, cfg_div = 8'd4;
   logic        bclk_i = 1, fsync_i = 0, sdin_drv = 0, loop = 0;
   logic        sdin, bclk_o, fsync_o, sdout, tx_ready, rx_valid, underrun;
   logic        tx_valid = 0;
   logic [31:0] tx_l = 0, tx_r = 0, rx_l, rx_r;

   int checks = 0, fails = 0;
   int got_n = 0;
   logic [31:0] got_l, got_r;
   int fs_run = 0, fs_last = 0, fs_slave_hi = 0;
   int bc_cnt = 0, bc_per = 0;
   logic bc_d = 1;

   assign sdin = loop ? sdout : sdin_drv;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsp_serial_port uut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt_b(cfg_fmt_b),
      .cfg_bclk_fall(cfg_bclk_fall), .cfg_word_len(cfg_word_len),
      .cfg_frame_len(cfg_frame_len), .cfg_div(cfg_div), .bclk_i(bclk_i),
      .fsync_i(fsync_i), .sdin(sdin), .bclk_o(bclk_o), .fsync_o(fsync_o),
      .sdout(sdout), .tx_l(tx_l), .tx_r(tx_r), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_l(rx_l), .rx_r(rx_r), .rx_valid(rx_valid),
      .underrun(underrun)
   );

   // Output monitors.
   always @(posedge clk) begin
      if (rx_valid) begin
         got_n = got_n + 1;
         got_l = rx_l;
         got_r = rx_r;
      end
      if (fsync_o) fs_run = fs_run + 1;
      else begin
         if (fs_run != 0) fs_last = fs_run;
         fs_run = 0;
      end
      if (!cfg_master && fsync_o) fs_slave_hi = fs_slave_hi + 1;
      bc_cnt = bc_cnt + 1;
      if (bclk_o && !bc_d) begin
         bc_per = bc_cnt;
         bc_cnt = 0;
      end
      bc_d = bclk_o;
   end

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mask(input int wl);
      return (wl >= 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 32'h1);
   endfunction

   function automatic logic slot_bit(input int s, input int off, input int wl,
                                     input logic [31:0] l, input logic [31:0] r);
      int p;
      if (s < off) return 1'b0;
      p = s - off;
      if (p < wl)     return l[wl-1-p];
      if (p < 2 * wl) return r[2*wl-1-p];
      return 1'b0;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset;
      rst_n = 0;
      wait_clk(4);
      rst_n = 1;
      wait_clk(1);
   endtask

   // Slave-mode frame: the bench plays the link master.
   task automatic run_vec(input int idx);
      vec_t v;
      logic has_tx, fb, ff, llvl, exp_tx;
      int wl, fl, fsw, off, mism;
      logic [31:0] rl, rr, tl, tr;
      v = VEC[idx];
      has_tx = v[88]; fb = v[87]; ff = v[86];
      wl = int'(v[85:80]); fl = int'(v[79:72]); fsw = int'(v[71:64]);
      rl = v[63:32]; rr = v[31:0];
      tl = rr ^ 32'hA5A5_0F0F;
      tr = {rl[15:0], rl[31:16]};
      off = fb ? 0 : 1;
      llvl = ff;
      cfg_master = 0; cfg_fmt_b = fb; cfg_bclk_fall = ff;
      cfg_word_len = 6'(wl); cfg_frame_len = 8'(fl);
      bclk_i = !llvl; fsync_i = 0; sdin_drv = 0; loop = 0;
      do_reset;
      if (has_tx) begin
         tx_l = tl; tx_r = tr; tx_valid = 1;
         wait_clk(1);
         tx_valid = 0;
      end
      wait_clk(4);
      got_n = 0; fs_slave_hi = 0; mism = 0;
      for (int s = 0; s < fl; s++) begin
         bclk_i = llvl;
         fsync_i = (s < fsw);
         sdin_drv = slot_bit(s, off, wl, rl, rr);
         wait_clk(HALF);
         exp_tx = has_tx ? slot_bit(s, off, wl, tl & mask(wl), tr & mask(wl)) : 1'b0;
         if (sdout !== exp_tx) mism++;
         bclk_i = !llvl;
         wait_clk(HALF);
      end
      fsync_i = 0; sdin_drv = 0;
      wait_clk(10);
      // R3 R4 R5: slot placement, order and zero fill of the sent frame
      check("R4", 64'(mism), 64'd0, $sformatf("vec %0d sdout slot mismatches", idx));
      // R1 R6: one received pair per frame, masked to the word length
      check("R6", 64'(got_n), 64'd1, $sformatf("vec %0d rx_valid strobes", idx));
      check("R1", 64'(got_l), 64'(rl & mask(wl)), $sformatf("vec %0d rx_l", idx));
      check("R3", 64'(got_r), 64'(rr & mask(wl)), $sformatf("vec %0d rx_r", idx));
      check("R8", 64'(underrun), 64'(!has_tx), $sformatf("vec %0d underrun", idx));
      check("R2", 64'(fs_slave_hi), 64'd0, $sformatf("vec %0d slave fsync_o", idx));
   endtask

   task automatic wait_rx(input int n);
      for (int t = 0; t < 2000 && got_n < n; t++) wait_clk(1);
   endtask

   initial begin
      // R10: reset state
      cfg_master = 0; cfg_bclk_fall = 0; bclk_i = 1;
      rst_n = 0;
      wait_clk(4);
      check("R10", 64'(tx_ready), 64'd1, "tx_ready in reset");
      check("R10", 64'(rx_valid), 64'd0, "rx_valid in reset");
      check("R10", 64'(underrun), 64'd0, "underrun in reset");
      check("R10", 64'(fsync_o), 64'd0, "fsync_o in reset");
      check("R10", 64'(sdout), 64'd0, "sdout in reset");
      check("R9", 64'(bclk_o), 64'd1, "bclk_o idle level");

      for (int i = 0; i < NVEC; i++) run_vec(i);

      // R7: holding stage fills on accept
      cfg_master = 0; cfg_fmt_b = 1; cfg_bclk_fall = 0;
      cfg_word_len = 6'd16; cfg_frame_len = 8'd40; bclk_i = 1;
      do_reset;
      tx_l = 32'h1111; tx_r = 32'h2222; tx_valid = 1;
      wait_clk(1);
      tx_valid = 0;
      check("R7", 64'(tx_ready), 64'd0, "tx_ready after accept");

      // Master mode with loopback: R2, R7, R8, R9
      cfg_master = 1; cfg_fmt_b = 0; cfg_bclk_fall = 0;
      cfg_word_len = 6'd16; cfg_frame_len = 8'd40; cfg_div = 8'd4;
      loop = 1;
      do_reset;
      got_n = 0;
      tx_l = 32'hFFFF_C0DE; tx_r = 32'h0000_7E57; tx_valid = 1;
      wait_clk(1);
      tx_valid = 0;
      wait_rx(1);
      check("R7", 64'(got_l), 64'h0000_C0DE, "master loopback rx_l");
      check("R7", 64'(got_r), 64'h0000_7E57, "master loopback rx_r");
      check("R7", 64'(tx_ready), 64'd1, "tx_ready after frame load");
      check("R8", 64'(underrun), 64'd0, "no underrun while pair held");
      check("R2", 64'(fs_last), 64'd8, "master fsync_o width in clk");
      check("R9", 64'(bc_per), 64'd8, "master bit clock period");
      wait_rx(2);
      check("R8", 64'(got_n), 64'd2, "second frame received");
      check("R8", 64'(got_l), 64'd0, "underrun frame left word");
      check("R8", 64'(got_r), 64'd0, "underrun frame right word");
      check("R8", 64'(underrun), 64'd1, "underrun set");
      loop = 0;

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule